// File: doc/BRIEF.md
# UART Register and Status Controller

This block is the software-visible front end of a simple serial port that holds one character in each direction. A 32-bit register bus is decoded by word index, where the index is the byte address shifted right by two. Behind the bus sit control, status, baud-setting and test registers, a one-character receive holding word and a transmit strobe. Bit-level framing, baud generation, FIFOs, DMA and modem lines are outside the block. The baud-related registers only store what software writes and return it.

A byte-wide receive port delivers characters and break events. The port takes a character only while nothing is held. Software reads the receive register to consume the held character, and that read also marks the returned word as valid. A write to the transmit register emits its low byte as a one-cycle strobe, provided transmission is enabled. A single level interrupt combines the receive-ready and transmit-ready conditions with their enables. Writing control register 2 with its bit 0 at zero performs a soft reset of the block.

Top module: `uart_csr_front`

## Requirements
- R1: After hardware reset the registers read as follows. Status 1 (index 0x25) reads 0x6040: transmit-ready at bit 13, RTS-state at bit 14, receiver-idle at bit 6. Status 2 (0x26) reads 0x4028. The test register (0x2D) reads 0x0060: receive-empty at bit 5, transmit-empty at bit 6. Control 1 (0x20) reads 0, control 2 (0x21) reads 0x0001, control 3 (0x22) reads 0x0700, the modulator (0x2A) reads 0, the baud count (0x2B) reads 4, and FIFO control (0x24) and the millisecond register (0x2C) read 0. The receive register (0x00) reads 0x4000, which is the error flag at bit 14. `rx_ready` is 1 and `irq` is 0.
- R2: Writes to control 1, control 3, FIFO control, the modulator and the millisecond register keep only bits 15:0 and read back at the same index. A write to the baud-increment index 0x29 is stored in the baud count, which reads back at 0x2B.
- R3: When `rx_valid` is high while `rx_ready` is high, the data byte is held. Status 1 bit 9 and status 2 bit 0 are set, test register bit 5 is cleared, and `rx_ready` falls.
- R4: A read of index 0x00 while a character is held returns the holding word with bit 15 set. That read clears status 1 bit 9 and status 2 bit 0, sets test bit 5 and raises `rx_ready`. A read while nothing is held returns the stale holding word with bit 15 clear.
- R5: A break event (`rx_break` with `rx_valid`) loads the holding word with 0x0800, which is the break flag at bit 11. It then behaves like a received character.
- R6: While a character is held, any further `rx_valid` is refused, and the held word and flags are kept.
- R7: A write to index 0x10 while control 2 bit 2 (transmit enable) is set produces `tx_valid` high for exactly the next cycle, with `tx_data` equal to the written bits 7:0. Without that enable, no strobe is produced.
- R8: Transmit-ready (status 1 bit 13) is low during exactly the cycle in which `tx_valid` is high.
- R9: `irq` is high when either of two conditions holds. The first is receive-ready together with control 1 bit 9. The second is transmit-ready together with control 1 bit 13 and control 1 bit 6.
- R10: A write to control 2 with bit 0 at 0 restores the R1 values of status 1, status 2, the test register, control 1, control 3, the modulator, the baud count and the holding word. FIFO control and the millisecond register keep their values. Every control 2 write stores bits 15:0 with bit 0 forced to 1.
- R11: Writing ones to status 1 or status 2 clears only the status 1 bits {15,12,11,10,8,7,5,4} and the status 2 bits {15,13,12,11,10,8,7,6,4,2,1}. The ready, data-ready, idle, RTS-state, FIFO-empty, done and DCD-in bits are unchanged.
- R12: Writes to the test register and to control 4 (0x23) are ignored. Reads of control 4, of 0x29, of 0x10 and of unmapped indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits above 1 form the word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| rx_valid | input | 1 | Receive event offered |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Event is a break rather than a byte |
| rx_ready | output | 1 | Block can accept a receive event |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Byte being transmitted |
| irq | output | 1 | Level interrupt |

## Verification
Directed sequences cover several cases: each register index is read after reset, soft reset and masked writes, and one character or break is held, refused, consumed and read stale. These sequences separate the consuming read path from the stale one and the break word from a data byte. A seeded random mix then interleaves receive pushes, receive reads, transmit writes with the enable on or off, and random interrupt-enable settings. After every step `irq` is compared with a bench model. This separates the receive-ready term from the transmit-ready term and exposes the one-cycle transmit-ready dip.

// File: rtl/uart_rc_pkg.sv
package uart_rc_pkg;
  localparam int REG_W  = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 10;

  localparam logic [IDX_W-1:0] IX_RXD  = 10'h000;
  localparam logic [IDX_W-1:0] IX_TXD  = 10'h010;
  localparam logic [IDX_W-1:0] IX_CTL1 = 10'h020;
  localparam logic [IDX_W-1:0] IX_CTL2 = 10'h021;
  localparam logic [IDX_W-1:0] IX_CTL3 = 10'h022;
  localparam logic [IDX_W-1:0] IX_CTL4 = 10'h023;
  localparam logic [IDX_W-1:0] IX_FIFO = 10'h024;
  localparam logic [IDX_W-1:0] IX_STS1 = 10'h025;
  localparam logic [IDX_W-1:0] IX_STS2 = 10'h026;
  localparam logic [IDX_W-1:0] IX_BINC = 10'h029;
  localparam logic [IDX_W-1:0] IX_BMOD = 10'h02A;
  localparam logic [IDX_W-1:0] IX_BCNT = 10'h02B;
  localparam logic [IDX_W-1:0] IX_MSEC = 10'h02C;
  localparam logic [IDX_W-1:0] IX_TEST = 10'h02D;

  // status 1 bits
  localparam int B_S1_RXIDLE = 6;
  localparam int B_S1_RRDY   = 9;
  localparam int B_S1_TRDY   = 13;
  localparam int B_S1_RTSS   = 14;
  // status 2 bits
  localparam int B_S2_RDR    = 0;
  localparam int B_S2_TXDC   = 3;
  localparam int B_S2_DCDIN  = 5;
  localparam int B_S2_TXFE   = 14;
  // control bits
  localparam int B_C1_TXE_IE  = 6;
  localparam int B_C1_RRDY_IE = 9;
  localparam int B_C1_TRDY_IE = 13;
  localparam int B_C2_SRST    = 0;
  localparam int B_C2_TXEN    = 2;
  // receive word and test register bits
  localparam int B_RX_BRK     = 11;
  localparam int B_RX_ERR     = 14;
  localparam int B_RX_CHRDY   = 15;
  localparam int B_TS_RXEMPTY = 5;
  localparam int B_TS_TXEMPTY = 6;

  localparam logic [REG_W-1:0] ONE16 = 16'h0001;
  localparam logic [REG_W-1:0] M_TRDY = ONE16 << B_S1_TRDY;
  localparam logic [REG_W-1:0] M_RRDY = ONE16 << B_S1_RRDY;

  localparam logic [REG_W-1:0] RST_STS1 = M_TRDY | (ONE16 << B_S1_RXIDLE) | (ONE16 << B_S1_RTSS);
  localparam logic [REG_W-1:0] RST_STS2 = (ONE16 << B_S2_TXFE) | (ONE16 << B_S2_TXDC) | (ONE16 << B_S2_DCDIN);
  localparam logic [REG_W-1:0] RST_TEST = (ONE16 << B_TS_RXEMPTY) | (ONE16 << B_TS_TXEMPTY);
  localparam logic [REG_W-1:0] RST_HOLD = ONE16 << B_RX_ERR;
  localparam logic [REG_W-1:0] RST_CTL1 = 16'h0000;
  localparam logic [REG_W-1:0] RST_CTL2 = ONE16 << B_C2_SRST;

  // clearable status bits
  localparam logic [REG_W-1:0] W1C_STS1 = (ONE16 << 15) | (ONE16 << 12) | (ONE16 << 11) |
                                          (ONE16 << 10) | (ONE16 << 8)  | (ONE16 << 7)  |
                                          (ONE16 << 5)  | (ONE16 << 4);
  localparam logic [REG_W-1:0] W1C_STS2 = (ONE16 << 15) | (ONE16 << 13) | (ONE16 << 12) |
                                          (ONE16 << 11) | (ONE16 << 10) | (ONE16 << 8)  |
                                          (ONE16 << 7)  | (ONE16 << 6)  | (ONE16 << 4)  |
                                          (ONE16 << 2)  | (ONE16 << 1);

  // plain storage registers: slot numbers, reset values, soft-reset membership
  localparam int NPLAIN = 5;
  localparam int P_CTL3 = 0;
  localparam int P_FIFO = 1;
  localparam int P_BMOD = 2;
  localparam int P_BCNT = 3;
  localparam int P_MSEC = 4;
  localparam logic [NPLAIN*REG_W-1:0] PLAIN_RST = {16'h0000, 16'h0004, 16'h0000, 16'h0000, 16'h0700};
  localparam logic [NPLAIN-1:0]       PLAIN_SOFT = 5'b01101;

  typedef struct packed {
    logic rxd_rd;
    logic txd_wr;
    logic ctl1_wr;
    logic ctl2_wr;
    logic ctl3_wr;
    logic fifo_wr;
    logic sts1_wr;
    logic sts2_wr;
    logic binc_wr;
    logic bmod_wr;
    logic msec_wr;
  } bus_strobe_t;

  function automatic logic irq_eval(input logic [REG_W-1:0] sts1, input logic [REG_W-1:0] ctl1);
    logic [REG_W-1:0] f;
    f = sts1 & ctl1 & (M_TRDY | M_RRDY);
    if (!ctl1[B_C1_TXE_IE]) f[B_S1_TRDY] = 1'b0;
    return |f;
  endfunction

  function automatic logic [REG_W-1:0] w1c_apply(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] wr,
                                                 input logic [REG_W-1:0] mask);
    return cur & ~(wr & mask);
  endfunction

  function automatic logic [REG_W-1:0] rx_hold_word(input logic brk, input logic [7:0] data);
    return brk ? (ONE16 << B_RX_BRK) : {8'h00, data};
  endfunction

  function automatic logic [DATA_W-1:0] rx_read_word(input logic [REG_W-1:0] hold, input logic empty);
    logic [REG_W-1:0] w;
    w = hold;
    if (!empty) w[B_RX_CHRDY] = 1'b1;
    return {16'h0000, w};
  endfunction
endpackage

// File: rtl/uart_rc_decode.sv
module uart_rc_decode
  import uart_rc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output bus_strobe_t       stb
);
  logic wr_en, rd_en;

  assign idx   = IDX_W'(addr[ADDR_W-1:2]);
  assign wr_en = req & we;
  assign rd_en = req & ~we;

  always_comb begin
    stb         = '0;
    stb.rxd_rd  = rd_en && (idx == IX_RXD);
    stb.txd_wr  = wr_en && (idx == IX_TXD);
    stb.ctl1_wr = wr_en && (idx == IX_CTL1);
    stb.ctl2_wr = wr_en && (idx == IX_CTL2);
    stb.ctl3_wr = wr_en && (idx == IX_CTL3);
    stb.fifo_wr = wr_en && (idx == IX_FIFO);
    stb.sts1_wr = wr_en && (idx == IX_STS1);
    stb.sts2_wr = wr_en && (idx == IX_STS2);
    stb.binc_wr = wr_en && (idx == IX_BINC);
    stb.bmod_wr = wr_en && (idx == IX_BMOD);
    stb.msec_wr = wr_en && (idx == IX_MSEC);
  end
endmodule

// File: rtl/uart_rc_cfg.sv
module uart_rc_cfg
  import uart_rc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic                    ctl1_wr,
  input  logic                    ctl2_wr,
  input  logic [NPLAIN-1:0]       plain_wr,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        ctl1_q,
  output logic [REG_W-1:0]        ctl2_q,
  output logic [NPLAIN*REG_W-1:0] plain_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q <= RST_CTL1;
      ctl2_q <= RST_CTL2;
    end else begin
      if (soft_rst)     ctl1_q <= RST_CTL1;
      else if (ctl1_wr) ctl1_q <= wdata;
      if (ctl2_wr)      ctl2_q <= wdata | (ONE16 << B_C2_SRST);
    end
  end

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    localparam logic [REG_W-1:0] RV = PLAIN_RST[g*REG_W +: REG_W];
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= RV;
      else if (soft_rst && PLAIN_SOFT[g]) q <= RV;
      else if (plain_wr[g])              q <= wdata;
    end
    assign plain_flat[g*REG_W +: REG_W] = q;
  end
endmodule

// File: rtl/uart_rc_rxtx.sv
module uart_rc_rxtx
  import uart_rc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_break,
  output logic             rx_ready,
  input  logic             rxd_rd,
  input  logic             txd_wr,
  input  logic             tx_en,
  input  logic             sts1_wr,
  input  logic             sts2_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] sts1_view,
  output logic [REG_W-1:0] sts2_q,
  output logic [REG_W-1:0] test_q,
  output logic [REG_W-1:0] hold_q,
  output logic             rx_take,
  output logic             rx_consume,
  output logic             tx_valid,
  output logic [7:0]       tx_data
);
  logic [REG_W-1:0] sts1_q, sts1_d, sts2_d, test_d, hold_d;
  logic             tx_fire;

  assign rx_ready   = ~sts1_q[B_S1_RRDY];
  assign rx_take    = rx_valid & rx_ready & ~soft_rst;
  assign rx_consume = rxd_rd & ~test_q[B_TS_RXEMPTY] & ~soft_rst;
  assign tx_fire    = txd_wr & tx_en & ~soft_rst;

  always_comb begin
    sts1_d = sts1_q;
    sts2_d = sts2_q;
    test_d = test_q;
    hold_d = hold_q;
    if (sts1_wr) sts1_d = w1c_apply(sts1_q, wdata, W1C_STS1);
    if (sts2_wr) sts2_d = w1c_apply(sts2_q, wdata, W1C_STS2);
    if (rx_take) begin
      sts1_d[B_S1_RRDY]    = 1'b1;
      sts2_d[B_S2_RDR]     = 1'b1;
      test_d[B_TS_RXEMPTY] = 1'b0;
      hold_d               = rx_hold_word(rx_break, rx_data);
    end
    if (rx_consume) begin
      sts1_d[B_S1_RRDY]    = 1'b0;
      sts2_d[B_S2_RDR]     = 1'b0;
      test_d[B_TS_RXEMPTY] = 1'b1;
    end
    if (soft_rst) begin
      sts1_d = RST_STS1;
      sts2_d = RST_STS2;
      test_d = RST_TEST;
      hold_d = RST_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts1_q   <= RST_STS1;
      sts2_q   <= RST_STS2;
      test_q   <= RST_TEST;
      hold_q   <= RST_HOLD;
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else begin
      sts1_q   <= sts1_d;
      sts2_q   <= sts2_d;
      test_q   <= test_d;
      hold_q   <= hold_d;
      tx_valid <= tx_fire;
      if (tx_fire) tx_data <= wdata[7:0];
    end
  end

  // transmit-ready dips while the strobe is out
  assign sts1_view = tx_valid ? (sts1_q & ~M_TRDY) : sts1_q;
endmodule

// File: rtl/uart_csr_front.sv
module uart_csr_front
  import uart_rc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  logic [IDX_W-1:0]        idx;
  bus_strobe_t             stb;
  logic [REG_W-1:0]        wdata16;
  logic                    soft_rst;
  logic                    tx_en;
  logic [NPLAIN-1:0]       plain_wr;
  logic [REG_W-1:0]        ctl1_q, ctl2_q;
  logic [NPLAIN*REG_W-1:0] plain_flat;
  logic [REG_W-1:0]        sts1_view, sts2_q, test_q, hold_q;
  logic                    rx_take, rx_consume;

  assign wdata16  = bus_wdata[REG_W-1:0];
  assign soft_rst = stb.ctl2_wr & ~wdata16[B_C2_SRST];
  assign tx_en    = ctl2_q[B_C2_TXEN];

  always_comb begin
    plain_wr         = '0;
    plain_wr[P_CTL3] = stb.ctl3_wr;
    plain_wr[P_FIFO] = stb.fifo_wr;
    plain_wr[P_BMOD] = stb.bmod_wr;
    plain_wr[P_BCNT] = stb.binc_wr;
    plain_wr[P_MSEC] = stb.msec_wr;
  end

  uart_rc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req  (bus_req),
    .we   (bus_we),
    .addr (bus_addr),
    .idx  (idx),
    .stb  (stb)
  );

  uart_rc_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .ctl1_wr    (stb.ctl1_wr),
    .ctl2_wr    (stb.ctl2_wr),
    .plain_wr   (plain_wr),
    .wdata      (wdata16),
    .ctl1_q     (ctl1_q),
    .ctl2_q     (ctl2_q),
    .plain_flat (plain_flat)
  );

  uart_rc_rxtx u_rxtx (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_break   (rx_break),
    .rx_ready   (rx_ready),
    .rxd_rd     (stb.rxd_rd),
    .txd_wr     (stb.txd_wr),
    .tx_en      (tx_en),
    .sts1_wr    (stb.sts1_wr),
    .sts2_wr    (stb.sts2_wr),
    .wdata      (wdata16),
    .sts1_view  (sts1_view),
    .sts2_q     (sts2_q),
    .test_q     (test_q),
    .hold_q     (hold_q),
    .rx_take    (rx_take),
    .rx_consume (rx_consume),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data)
  );

  always_comb begin
    case (idx)
      IX_RXD:  bus_rdata = rx_read_word(hold_q, test_q[B_TS_RXEMPTY]);
      IX_CTL1: bus_rdata = {16'h0000, ctl1_q};
      IX_CTL2: bus_rdata = {16'h0000, ctl2_q};
      IX_CTL3: bus_rdata = {16'h0000, plain_flat[P_CTL3*REG_W +: REG_W]};
      IX_FIFO: bus_rdata = {16'h0000, plain_flat[P_FIFO*REG_W +: REG_W]};
      IX_STS1: bus_rdata = {16'h0000, sts1_view};
      IX_STS2: bus_rdata = {16'h0000, sts2_q};
      IX_BMOD: bus_rdata = {16'h0000, plain_flat[P_BMOD*REG_W +: REG_W]};
      IX_BCNT: bus_rdata = {16'h0000, plain_flat[P_BCNT*REG_W +: REG_W]};
      IX_MSEC: bus_rdata = {16'h0000, plain_flat[P_MSEC*REG_W +: REG_W]};
      IX_TEST: bus_rdata = {16'h0000, test_q};
      default: bus_rdata = 32'h0000_0000;
    endcase
  end

  assign irq = irq_eval(sts1_view, ctl1_q);
endmodule

// File: rtl/uart_rc_chk.sv
module uart_rc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_take,
  input logic        rx_consume,
  input logic        rx_ready,
  input logic        txd_wr,
  input logic        tx_en,
  input logic        tx_valid,
  input logic [15:0] sts1_view,
  input logic [15:0] ctl1_q,
  input logic [15:0] ctl2_q,
  input logic [15:0] ctl3_q,
  input logic        soft_rst,
  input logic        irq
);
  p_take_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> !rx_ready);

  p_consume_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_consume |=> rx_ready);

  p_tx_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(txd_wr && tx_en));

  p_tx_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && !tx_en) |=> !tx_valid);

  p_trdy_dip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !sts1_view[13]);

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl1_q[9] && !ctl1_q[13]) |-> !irq);

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctl1_q == 16'h0000 && ctl3_q == 16'h0700 && rx_ready));

  p_ctl2_lsb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl2_q[0]);
endmodule

bind uart_csr_front uart_rc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_take    (rx_take),
  .rx_consume (rx_consume),
  .rx_ready   (rx_ready),
  .txd_wr     (stb.txd_wr),
  .tx_en      (tx_en),
  .tx_valid   (tx_valid),
  .sts1_view  (sts1_view),
  .ctl1_q     (ctl1_q),
  .ctl2_q     (ctl2_q),
  .ctl3_q     (plain_flat[15:0]),
  .soft_rst   (soft_rst),
  .irq        (irq)
);

// File: tb/test_uart_csr_front.sv
`timescale 1ns/1ps
module test_uart_csr_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  always #2.5 clk = ~clk;

  uart_csr_front i_uart_csr_front (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  localparam int A_RXD = 'h00, A_TXD = 'h10, A_C1 = 'h20, A_C2 = 'h21, A_C3 = 'h22, A_C4 = 'h23;
  localparam int A_FC = 'h24, A_S1 = 'h25, A_S2 = 'h26, A_BI = 'h29, A_BM = 'h2A, A_BC = 'h2B;
  localparam int A_MS = 'h2C, A_TS = 'h2D;

  int n_tot = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] v;

  // bench model
  bit          m_rrdy;
  logic [15:0] m_hold;
  logic [15:0] m_c1;
  bit          m_txen;

  function automatic bit exp_irq(bit rrdy, bit trdy, logic [15:0] c1);
    return (rrdy && c1[9]) || (trdy && c1[13] && c1[6]);
  endfunction

  function automatic logic [31:0] exp_rx(bit held, logic [15:0] hold);
    return held ? {16'h0, hold | 16'h8000} : {16'h0, hold};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ix, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'(ix * 4); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int ix, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'(ix * 4);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input bit brk);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_break = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic rdchk(input string tag, input int ix, input logic [31:0] exp);
    logic [31:0] d;
    rd(ix, d);
    chk(tag, d, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk("R1 rx_ready", rx_ready, 1);
    chk("R1 irq", irq, 0);
    rdchk("R1 sts1", A_S1, 32'h6040);
    rdchk("R1 sts2", A_S2, 32'h4028);
    rdchk("R1 test", A_TS, 32'h0060);
    rdchk("R1 ctl1", A_C1, 0);
    rdchk("R1 ctl2", A_C2, 32'h0001);
    rdchk("R1 ctl3", A_C3, 32'h0700);
    rdchk("R1 bmod", A_BM, 0);
    rdchk("R1 bcnt", A_BC, 4);
    rdchk("R1 fifo", A_FC, 0);
    rdchk("R1 msec", A_MS, 0);
    rdchk("R1 rxd", A_RXD, 32'h4000);

    // R2 masked storage
    wr(A_C1, 32'hABCD_1234); rdchk("R2 ctl1", A_C1, 32'h1234);
    wr(A_C1, 0);
    wr(A_C3, 32'hFFFF_5A5A); rdchk("R2 ctl3", A_C3, 32'h5A5A);
    wr(A_FC, 32'h1234_5678); rdchk("R2 fifo", A_FC, 32'h5678);
    wr(A_BM, 32'h0F0F_00C3); rdchk("R2 bmod", A_BM, 32'h00C3);
    wr(A_MS, 32'hFFFF_BEEF); rdchk("R2 msec", A_MS, 32'hBEEF);
    wr(A_BI, 32'h0001_00FF); rdchk("R2 bcnt via inc", A_BC, 32'h00FF);

    // R12 ignored and zero reads
    rdchk("R12 inc reads 0", A_BI, 0);
    wr(A_TS, 32'h0000_0000); rdchk("R12 test kept", A_TS, 32'h0060);
    wr(A_C4, 32'hFFFF_FFFF); rdchk("R12 ctl4", A_C4, 0);
    rdchk("R12 unmapped", 'h30, 0);
    rdchk("R12 txd reads 0", A_TXD, 0);
    wr(A_BC, 32'h0000_1111); rdchk("R12 bcnt not writable", A_BC, 32'h00FF);

    // R3 / R4 receive and consume
    push(8'hA5, 0);
    chk("R3 rx_ready low", rx_ready, 0);
    rdchk("R3 sts1 rrdy", A_S1, 32'h6240);
    rdchk("R3 sts2 rdr", A_S2, 32'h4029);
    rdchk("R3 test rxempty clr", A_TS, 32'h0040);
    rdchk("R4 consume", A_RXD, 32'h80A5);
    chk("R4 rx_ready back", rx_ready, 1);
    rdchk("R4 stale", A_RXD, 32'h00A5);
    rdchk("R4 sts1", A_S1, 32'h6040);
    rdchk("R4 test", A_TS, 32'h0060);

    // R6 refusal
    push(8'h11, 0);
    push(8'h22, 0);
    rdchk("R6 first kept", A_RXD, 32'h8011);

    // R5 break
    push(8'h5C, 1);
    chk("R5 rx_ready", rx_ready, 0);
    rdchk("R5 break word", A_RXD, 32'h8800);

    // R11 w1c leaves other bits
    push(8'h3C, 0);
    wr(A_S1, 32'h0000_FFFF); rdchk("R11 sts1", A_S1, 32'h6240);
    wr(A_S2, 32'h0000_FFFF); rdchk("R11 sts2", A_S2, 32'h4029);
    chk("R11 rx_ready", rx_ready, 0);

    // R9 receive term
    wr(A_C1, 32'h0200); chk("R9 rx irq", irq, 1);
    rdchk("R9 consume", A_RXD, 32'h803C);
    @(negedge clk); chk("R9 rx irq gone", irq, 0);

    // R7 / R8 / R9 transmit
    wr(A_C1, 32'h2000); chk("R9 trdy without empty en", irq, 0);
    wr(A_C1, 32'h2040); chk("R9 trdy irq", irq, 1);
    wr(A_C2, 32'h0005);
    wr(A_TXD, 32'hDEAD_BEC3);
    chk("R7 strobe", tx_valid, 1);
    chk("R7 data", tx_data, 8'hC3);
    chk("R8 irq dip", irq, 0);
    @(negedge clk);
    chk("R7 one cycle", tx_valid, 0);
    chk("R8 irq back", irq, 1);
    wr(A_C2, 32'h0001);
    wr(A_TXD, 32'h0000_0077);
    chk("R7 disabled", tx_valid, 0);

    // R10 soft reset
    push(8'h99, 0);
    wr(A_C3, 32'h1234);
    wr(A_C2, 32'h0006);
    rdchk("R10 ctl2 forced", A_C2, 32'h0007);
    rdchk("R10 ctl1", A_C1, 0);
    rdchk("R10 ctl3", A_C3, 32'h0700);
    rdchk("R10 bcnt", A_BC, 4);
    rdchk("R10 bmod", A_BM, 0);
    rdchk("R10 sts1", A_S1, 32'h6040);
    rdchk("R10 sts2", A_S2, 32'h4028);
    rdchk("R10 test", A_TS, 32'h0060);
    rdchk("R10 hold", A_RXD, 32'h4000);
    rdchk("R10 fifo kept", A_FC, 32'h5678);
    rdchk("R10 msec kept", A_MS, 32'hBEEF);
    chk("R10 rx_ready", rx_ready, 1);

    // random mix, model resynced by soft reset
    wr(A_C2, 32'h0000_0000);
    m_rrdy = 0; m_hold = 16'h4000; m_c1 = 0; m_txen = 0;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 4))
        0: begin
          logic [7:0] b;
          bit brk;
          b = 8'($urandom);
          brk = ($urandom_range(0, 7) == 0);
          chk("R6 ready before push", rx_ready, !m_rrdy);
          push(b, brk);
          if (!m_rrdy) begin
            m_rrdy = 1;
            m_hold = brk ? 16'h0800 : {8'h00, b};
          end
        end
        1: begin
          rd(A_RXD, v);
          chk("R4 random read", v, exp_rx(m_rrdy, m_hold));
          m_rrdy = 0;
        end
        2: begin
          logic [31:0] d;
          d = $urandom;
          wr(A_TXD, d);
          chk("R7 random strobe", tx_valid, m_txen);
          if (m_txen) chk("R7 random data", tx_data, d[7:0]);
          chk("R8 random irq", irq, exp_irq(m_rrdy, !m_txen, m_c1));
        end
        3: begin
          m_c1 = 16'($urandom) & 16'h2241;
          wr(A_C1, {16'h0, m_c1});
        end
        default: begin
          m_txen = ($urandom_range(0, 1) == 1);
          wr(A_C2, m_txen ? 32'h0005 : 32'h0001);
        end
      endcase
      @(negedge clk);
      chk("R9 random irq", irq, exp_irq(m_rrdy, 1, m_c1));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule